// File: doc/BRIEF.md
# GPIO Bank Controller

A register-mapped controller for a bank of general-purpose pins. Software reaches it through a simple 32-bit port with separate read and write strobes. Three kinds of per-pin state sit behind that port.

- **Bit-per-pin banks.** Each bank is a run of 32-bit words, and pin `p` occupies bit `p mod 32` of word `p/32`. There are three such banks:
  - firmware ownership, read-only;
  - interrupt status, write-one-to-clear;
  - interrupt enable, read-write.
- **A global control word.** It steers the combined interrupt onto one of two upstream lines.
- **Per-pin configuration words.** Each pin has two 32-bit words. They set output level, direction, native-or-GPIO use, trigger mode and invert, input-sensing disable and weak-pull choice.

The block drives each pin's output enable and output value. It exports the pull code and the trigger settings to the pad and interrupt logic. It brings each pin's input through a two-flop synchroniser so that the input level can be read back.

Edge and level detection belongs to a neighbouring interrupt block. That block raises `irq_event` bits, which set status bits here. The status bits, masked by the enable bits, drive the selected upstream line.

The register port is handled by a two-state machine.

- **States.**
  - `ST_IDLE`: no read response is pending.
  - `ST_RESP`: drives `rd_valid` together with the data captured on the previous edge.
- **Transitions.**
  - *accept* (`ST_IDLE` to `ST_RESP`): taken when `rd_en` is high.
  - *chain* (`ST_RESP` to `ST_RESP`): taken when a new read arrives during a response.
  - *retire* (`ST_RESP` to `ST_IDLE`): taken when no read arrives.
- **Writes.** They take effect on the edge that samples `wr_en` and do not involve the state machine.
- **A read and a write in the same cycle.** The read returns the value from before the write.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is in this state:
  - configuration word 1 reads 0x00000004 (input, native use);
  - configuration word 2 reads 0x00000004 (sensing disabled, no pull);
  - enable words and the control word read 0;
  - all `pin_oe` bits are low.
- R2: A read strobe sampled on one edge raises `rd_valid` for the following cycle, with `rdata` holding the addressed word. `rd_valid` is low when no read was issued on the previous edge.
- R3: Configuration word 1 of pin p is at byte offset 0x100+8p and has these fields:
  - bit 31: output level, which drives `pin_out[p]`;
  - bit 4: level trigger, which drives `trig_level[p]`;
  - bit 3: invert, which drives `trig_invert[p]`;
  - bit 2: direction, 1 = input;
  - bit 0: use, 1 = GPIO.

  All other bits, apart from bit 30, read 0.
- R4: `pin_oe[p]` is high exactly when pin p has use = 1 and direction = 0.
- R5: Bit 30 of configuration word 1 ignores writes. It reads the two-flop-synchronised `pin_in[p]` while sensing is enabled, and reads 0 while sensing is disabled.
- R6: Configuration word 2 of pin p is at 0x104+8p and has these fields:
  - bit 2: disables input sensing;
  - bits 1:0: pull code, which drives `pin_pull[2p+1:2p]`.
- R7: The ownership bank at 0x00+4w returns `own_map` bits, zero beyond the last pin. Writes to it are ignored.
- R8: The status bank at 0x80+4w has these rules:
  - an `irq_event` bit sets its status bit;
  - writing 1 to a status bit clears it;
  - a set in the same cycle as a clear wins.
- R9: The enable bank at 0x90+4w is read-write. Bits beyond the last pin read 0.
- R10: Bit 0 of the control word at 0x7C selects which line carries the OR of (status AND enable):
  - 0 selects `irq_line0`;
  - 1 selects `irq_line1`.

  The unselected line stays low.
- R11: Reads of unmapped offsets return 0, and writes to them change nothing. This includes the configuration slot just past the last pin and bank words beyond the last pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rdata | output | 32 | Read response data |
| own_map | input | NUM_PINS | Firmware ownership bits, 0 = reserved |
| irq_event | input | NUM_PINS | Per-pin interrupt set pulses |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_oe | output | NUM_PINS | Pin output enables |
| pin_out | output | NUM_PINS | Pin output values |
| pin_pull | output | 2*NUM_PINS | Pull code, two bits per pin |
| trig_level | output | NUM_PINS | Trigger mode, 1 = level |
| trig_invert | output | NUM_PINS | Trigger polarity invert |
| irq_line0 | output | 1 | Upstream interrupt line, control bit 0 = 0 |
| irq_line1 | output | 1 | Upstream interrupt line, control bit 0 = 1 |

## Verification
The bench builds the block with `NUM_PINS` = 40, so each bank has one full word and one partial word. This brings within reach:
- the zero padding above bit 7 of the second enable and ownership words;
- the unmapped third bank word;
- the unmapped configuration slot at 0x240, right after the last pin.

Pin 33 sits in the second word, so status set, clear, set-versus-clear collision and line selection are all checked across the word boundary.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Word offsets (byte offset / 4) of each register group
    localparam int OWN_WORD  = 'h00 / 4;
    localparam int CTRL_WORD = 'h7C / 4;
    localparam int STAT_WORD = 'h80 / 4;
    localparam int EN_WORD   = 'h90 / 4;
    localparam int CFG_WORD  = 'h100 / 4;

    // Configuration word 1 bit positions
    localparam int C1_OUT  = 31;
    localparam int C1_IN   = 30;
    localparam int C1_TLVL = 4;
    localparam int C1_TINV = 3;
    localparam int C1_DIR  = 2;
    localparam int C1_USE  = 0;

    // Configuration word 2 bit positions
    localparam int C2_SDIS = 2;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_OWN,
        RK_CTRL,
        RK_STAT,
        RK_EN,
        RK_CFG1,
        RK_CFG2
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_dis;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        out_lvl:   1'b0,
        trig_lvl:  1'b0,
        trig_inv:  1'b0,
        dir_in:    1'b1,
        use_gpio:  1'b0,
        sense_dis: 1'b1,
        pull:      2'b00
    };

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12,
    localparam int NWORDS  = (NUM_PINS + 31) / 32,
    localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [WIDX_W-1:0] widx,
    output logic [PIN_W-1:0]  pin
);

    int word;

    always_comb begin
        kind = RK_NONE;
        widx = '0;
        pin  = '0;
        word = int'(addr >> 2);
        if (word >= OWN_WORD && word < OWN_WORD + NWORDS) begin
            kind = RK_OWN;
            widx = WIDX_W'(word - OWN_WORD);
        end else if (word == CTRL_WORD) begin
            kind = RK_CTRL;
        end else if (word >= STAT_WORD && word < STAT_WORD + NWORDS) begin
            kind = RK_STAT;
            widx = WIDX_W'(word - STAT_WORD);
        end else if (word >= EN_WORD && word < EN_WORD + NWORDS) begin
            kind = RK_EN;
            widx = WIDX_W'(word - EN_WORD);
        end else if (word >= CFG_WORD && word < CFG_WORD + 2 * NUM_PINS) begin
            kind = (((word - CFG_WORD) % 2) == 1) ? RK_CFG2 : RK_CFG1;
            pin  = PIN_W'((word - CFG_WORD) / 2);
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 94
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 94,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_c1,
    input  logic                      wr_c2,
    input  logic [PIN_W-1:0]          pin,
    input  logic [31:0]               wdata,
    output pin_cfg_t [NUM_PINS-1:0]   cfg,
    output logic [NUM_PINS-1:0]       pin_oe,
    output logic [NUM_PINS-1:0]       pin_out,
    output logic [2*NUM_PINS-1:0]     pin_pull,
    output logic [NUM_PINS-1:0]       trig_level,
    output logic [NUM_PINS-1:0]       trig_invert
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_cfg_t q;
        logic     hit;

        assign hit = (pin == PIN_W'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= CFG_RESET;
            end else begin
                if (wr_c1 && hit) begin
                    q.out_lvl  <= wdata[C1_OUT];
                    q.trig_lvl <= wdata[C1_TLVL];
                    q.trig_inv <= wdata[C1_TINV];
                    q.dir_in   <= wdata[C1_DIR];
                    q.use_gpio <= wdata[C1_USE];
                end
                if (wr_c2 && hit) begin
                    q.sense_dis <= wdata[C2_SDIS];
                    q.pull      <= wdata[1:0];
                end
            end
        end

        assign cfg[p]            = q;
        assign pin_oe[p]         = q.use_gpio & ~q.dir_in;
        assign pin_out[p]        = q.out_lvl;
        assign pin_pull[2*p +: 2] = q.pull;
        assign trig_level[p]     = q.trig_lvl;
        assign trig_invert[p]    = q.trig_inv;
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
    parameter int NUM_PINS = 94,
    localparam int NWORDS  = (NUM_PINS + 31) / 32,
    localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stat,
    input  logic                wr_en_bank,
    input  logic                wr_ctrl,
    input  logic [WIDX_W-1:0]   widx,
    input  logic [31:0]         wdata,
    input  logic [NUM_PINS-1:0] irq_event,
    output logic [NUM_PINS-1:0] stat,
    output logic [NUM_PINS-1:0] int_en,
    output logic                line_sel,
    output logic                irq_line0,
    output logic                irq_line1
);

    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] en_hit;
    logic                any_irq;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
        assign clr_mask[p] = wr_stat && (widx == WIDX_W'(p / 32)) && wdata[p % 32];
        assign en_hit[p]   = wr_en_bank && (widx == WIDX_W'(p / 32));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat     <= '0;
            int_en   <= '0;
            line_sel <= 1'b0;
        end else begin
            // a new event outranks a clear in the same cycle
            stat <= irq_event | (stat & ~clr_mask);
            for (int p = 0; p < NUM_PINS; p++) begin
                if (en_hit[p]) int_en[p] <= wdata[p % 32];
            end
            if (wr_ctrl) line_sel <= wdata[0];
        end
    end

    assign any_irq   = |(stat & int_en);
    assign irq_line0 = any_irq & ~line_sel;
    assign irq_line1 = any_irq & line_sel;

endmodule

// File: rtl/gpio_reg_port.sv
module gpio_reg_port
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 94,
    localparam int NWORDS  = (NUM_PINS + 31) / 32,
    localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  reg_kind_e               kind,
    input  logic [WIDX_W-1:0]       widx,
    input  logic [PIN_W-1:0]        pin,
    input  logic [NUM_PINS-1:0]     own_map,
    input  logic [NUM_PINS-1:0]     stat,
    input  logic [NUM_PINS-1:0]     int_en,
    input  logic                    line_sel,
    input  pin_cfg_t [NUM_PINS-1:0] cfg,
    input  logic [NUM_PINS-1:0]     in_sync,
    output logic                    rd_valid,
    output logic [31:0]             rdata
);

    port_state_e state_q;
    port_state_e state_d;

    logic [NWORDS*32-1:0] own_pad;
    logic [NWORDS*32-1:0] stat_pad;
    logic [NWORDS*32-1:0] en_pad;
    logic [31:0]          rd_word;
    logic [31:0]          rdata_q;
    pin_cfg_t             sel_cfg;
    logic                 in_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_en) state_d = ST_RESP;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // read word assembly
    always_comb begin
        own_pad                = '0;
        stat_pad               = '0;
        en_pad                 = '0;
        own_pad[NUM_PINS-1:0]  = own_map;
        stat_pad[NUM_PINS-1:0] = stat;
        en_pad[NUM_PINS-1:0]   = int_en;
        sel_cfg                = cfg[pin];
        in_lvl                 = in_sync[pin] & ~sel_cfg.sense_dis;
        rd_word                = '0;
        unique case (kind)
            RK_OWN:  rd_word = own_pad[widx*32 +: 32];
            RK_STAT: rd_word = stat_pad[widx*32 +: 32];
            RK_EN:   rd_word = en_pad[widx*32 +: 32];
            RK_CTRL: rd_word = {31'b0, line_sel};
            RK_CFG1: begin
                rd_word[C1_OUT]  = sel_cfg.out_lvl;
                rd_word[C1_IN]   = in_lvl;
                rd_word[C1_TLVL] = sel_cfg.trig_lvl;
                rd_word[C1_TINV] = sel_cfg.trig_inv;
                rd_word[C1_DIR]  = sel_cfg.dir_in;
                rd_word[C1_USE]  = sel_cfg.use_gpio;
            end
            RK_CFG2: rd_word = {29'b0, sel_cfg.sense_dis, sel_cfg.pull};
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
        else            rdata_q <= '0;
    end

    // outputs
    always_comb begin
        rd_valid = 1'b0;
        rdata    = '0;
        unique case (state_q)
            ST_IDLE: rd_valid = 1'b0;
            ST_RESP: begin
                rd_valid = 1'b1;
                rdata    = rdata_q;
            end
            default: rd_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 94,   // up to 128: the status and enable banks must not overlap
    parameter int ADDR_W   = 12,
    localparam int NWORDS  = (NUM_PINS + 31) / 32,
    localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic                  rd_valid,
    output logic [31:0]           rdata,
    input  logic [NUM_PINS-1:0]   own_map,
    input  logic [NUM_PINS-1:0]   irq_event,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [2*NUM_PINS-1:0] pin_pull,
    output logic [NUM_PINS-1:0]   trig_level,
    output logic [NUM_PINS-1:0]   trig_invert,
    output logic                  irq_line0,
    output logic                  irq_line1
);

    reg_kind_e               kind;
    logic [WIDX_W-1:0]       widx;
    logic [PIN_W-1:0]        pin;
    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     in_sync;
    logic [NUM_PINS-1:0]     stat;
    logic [NUM_PINS-1:0]     int_en;
    logic                    line_sel;

    gpio_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .kind (kind),
        .widx (widx),
        .pin  (pin)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (in_sync)
    );

    gpio_pin_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_c1       (wr_en && kind == RK_CFG1),
        .wr_c2       (wr_en && kind == RK_CFG2),
        .pin         (pin),
        .wdata       (wdata),
        .cfg         (cfg),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out),
        .pin_pull    (pin_pull),
        .trig_level  (trig_level),
        .trig_invert (trig_invert)
    );

    gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_en && kind == RK_STAT),
        .wr_en_bank (wr_en && kind == RK_EN),
        .wr_ctrl    (wr_en && kind == RK_CTRL),
        .widx       (widx),
        .wdata      (wdata),
        .irq_event  (irq_event),
        .stat       (stat),
        .int_en     (int_en),
        .line_sel   (line_sel),
        .irq_line0  (irq_line0),
        .irq_line1  (irq_line1)
    );

    gpio_reg_port #(.NUM_PINS(NUM_PINS)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .kind     (kind),
        .widx     (widx),
        .pin      (pin),
        .own_map  (own_map),
        .stat     (stat),
        .int_en   (int_en),
        .line_sel (line_sel),
        .cfg      (cfg),
        .in_sync  (in_sync),
        .rd_valid (rd_valid),
        .rdata    (rdata)
    );

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic                rd_valid,
    input logic [31:0]         rdata,
    input logic [NUM_PINS-1:0] irq_event,
    input logic [NUM_PINS-1:0] int_en,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq_line0,
    input logic                irq_line1
);

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R10
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_line0, irq_line1}));

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_event & int_en)) && !wr_en |=> (irq_line0 || irq_line1));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'('h0F0)) |=> (rdata == 32'h0));

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rd_valid  (rd_valid),
    .rdata     (rdata),
    .irq_event (irq_event),
    .int_en    (int_en),
    .pin_oe    (pin_oe),
    .irq_line0 (irq_line0),
    .irq_line1 (irq_line1)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;

    localparam int N  = 40;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          rd_valid;
    logic [31:0]   rdata;
    logic [N-1:0]  own_map = 40'hA5_1234_5678;
    logic [N-1:0]  irq_event = '0;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_oe;
    logic [N-1:0]  pin_out;
    logic [2*N-1:0] pin_pull;
    logic [N-1:0]  trig_level;
    logic [N-1:0]  trig_invert;
    logic          irq_line0;
    logic          irq_line1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(N), .ADDR_W(AW)) u_gpio_bank_ctrl (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rd_valid (rd_valid), .rdata (rdata),
        .own_map (own_map), .irq_event (irq_event), .pin_in (pin_in),
        .pin_oe (pin_oe), .pin_out (pin_out), .pin_pull (pin_pull),
        .trig_level (trig_level), .trig_invert (trig_invert),
        .irq_line0 (irq_line0), .irq_line1 (irq_line1)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2 rd_valid after read", 64'(rd_valid), 64'd1);
        d = rdata;
    endtask

    function automatic logic [AW-1:0] c1(input int p);
        return AW'('h100 + 8 * p);
    endfunction

    function automatic logic [AW-1:0] c2(input int p);
        return AW'('h104 + 8 * p);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pin_oe after reset", 64'(pin_oe), 64'd0);
        check("R2 rd_valid idle", 64'(rd_valid), 64'd0);
        rd(c1(0), d);  check("R1 cfg1 pin0", 64'(d), 64'h4);
        rd(c2(39), d); check("R1 cfg2 pin39", 64'(d), 64'h4);
        rd(AW'('h90), d); check("R1 enable word0", 64'(d), 64'h0);
        rd(AW'('h7C), d); check("R1 control word", 64'(d), 64'h0);
        @(negedge clk);
        check("R2 rd_valid retires", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_cfg1();
        logic [31:0] d;
        wr(c1(5), 32'hFFFF_FFFF);
        rd(c1(5), d);
        check("R3 cfg1 fields, R5 bit30 ignores write", 64'(d), 64'h8000_001D);
        check("R3 pin_out follows bit31", 64'(pin_out[5]), 64'd1);
        check("R3 trig_level", 64'(trig_level[5]), 64'd1);
        check("R3 trig_invert", 64'(trig_invert[5]), 64'd1);
        check("R4 oe low when input", 64'(pin_oe[5]), 64'd0);
    endtask

    task automatic t_oe();
        wr(c1(5), 32'h8000_0001);
        check("R4 oe high gpio output", 64'(pin_oe), 64'(40'h20));
        wr(c1(5), 32'h0000_0000);
        check("R4 oe low native", 64'(pin_oe[5]), 64'd0);
        wr(c1(5), 32'h0000_0005);
        check("R4 oe low gpio input", 64'(pin_oe[5]), 64'd0);
    endtask

    task automatic t_sense();
        logic [31:0] d;
        @(negedge clk); pin_in[7] = 1'b1;
        wr(c2(7), 32'h0);
        repeat (3) @(negedge clk);
        rd(c1(7), d); check("R5 input high sensed", 64'(d), 64'h4000_0004);
        @(negedge clk); pin_in[7] = 1'b0;
        repeat (3) @(negedge clk);
        rd(c1(7), d); check("R5 input low sensed", 64'(d), 64'h0000_0004);
        wr(c2(7), 32'h4);
        @(negedge clk); pin_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        rd(c1(7), d); check("R5 sensing disabled reads 0", 64'(d), 64'h0000_0004);
    endtask

    task automatic t_pull();
        logic [31:0] d;
        wr(c2(3), 32'hFFFF_FFF2);
        rd(c2(3), d); check("R6 cfg2 readback", 64'(d), 64'h2);
        check("R6 pin_pull pin3", 64'(pin_pull[7:6]), 64'd2);
        check("R6 other pulls untouched", 64'(pin_pull[5:0]), 64'd0);
    endtask

    task automatic t_own();
        logic [31:0] d;
        rd(AW'('h00), d); check("R7 own word0", 64'(d), 64'h1234_5678);
        rd(AW'('h04), d); check("R7 own word1 padded", 64'(d), 64'hA5);
        wr(AW'('h00), 32'h0);
        rd(AW'('h00), d); check("R7 own write ignored", 64'(d), 64'h1234_5678);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(AW'('h94), 32'hFFFF_FFFF);
        rd(AW'('h94), d); check("R9 enable word1 padded", 64'(d), 64'hFF);
        @(negedge clk); irq_event[33] = 1'b1;
        @(negedge clk); irq_event[33] = 1'b0;
        check("R10 line0 carries irq", 64'({irq_line1, irq_line0}), 64'b01);
        rd(AW'('h84), d); check("R8 status set by event", 64'(d), 64'h2);
        wr(AW'('h7C), 32'h1);
        check("R10 line1 selected", 64'({irq_line1, irq_line0}), 64'b10);
        wr(AW'('h84), 32'h2);
        check("R8 status cleared by W1C", 64'({irq_line1, irq_line0}), 64'b00);
        @(negedge clk);
        addr = AW'('h84); wdata = 32'h4; wr_en = 1'b1; irq_event[34] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; irq_event[34] = 1'b0;
        rd(AW'('h84), d); check("R8 set wins over clear", 64'(d), 64'h4);
        wr(AW'('h84), 32'h4);
        rd(AW'('h84), d); check("R8 cleared afterwards", 64'(d), 64'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic [N-1:0] oe_before;
        rd(AW'('h0F0), d); check("R11 gap reads 0", 64'(d), 64'h0);
        rd(AW'('h08), d);  check("R11 own word2 reads 0", 64'(d), 64'h0);
        rd(AW'('h98), d);  check("R11 enable word2 reads 0", 64'(d), 64'h0);
        oe_before = pin_oe;
        wr(AW'('h240), 32'h8000_0001);
        check("R11 write past last pin no oe change", 64'(pin_oe), 64'(oe_before));
        rd(AW'('h240), d); check("R11 past last pin reads 0", 64'(d), 64'h0);
        rd(c1(0), d); check("R11 pin0 cfg untouched", 64'(d), 64'h4);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg1();
        t_oe();
        t_sense();
        t_pull();
        t_own();
        t_irq();
        t_unmapped();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule